// File: doc/BRIEF.md
# Wake Event Latch Unit

The unit watches two groups of asynchronous wake sources, one for internal event lines and one for external pins, and latches qualifying transitions so that a sleeping system can be woken. Each source bit is brought into the clock domain through a two-flop synchronizer, compared against its previous sampled value, and qualified by a per-bit polarity: rising when the polarity bit is 1, falling when it is 0. A qualifying edge sets a sticky raw status bit, whether or not the bit is enabled.

Each group has four registers reached through a small write port and a combinational read port: enable, polarity, raw status (write 1 to clear) and masked status (raw AND enable, read-only). The single wake request output is the OR of all masked status bits of both groups, so it stays high until software clears the latched bits or removes their enables.

Top module: `wake_latch_unit`

## Requirements
- R1: After reset both enable registers and both raw status registers read 0, the internal-group polarity reads INT_POL_RST (default 32'h0000_0700), the pin-group polarity reads 0 (all falling), and wake_o is 0; source levels present during reset and the first three clock edges after it latch no event.
- R2: With a polarity bit of 1, a 0-to-1 transition of that source sets its raw status bit; a 1-to-0 transition does not.
- R3: With a polarity bit of 0, a 1-to-0 transition of that source sets its raw status bit; a 0-to-1 transition does not.
- R4: A raw status bit latches on its selected edge even when its enable bit is 0, and such a bit does not raise wake_o.
- R5: Writing the raw status register (address field sel = 2) clears exactly the bits written as 1; bits written as 0 keep their value.
- R6: The masked status register (sel = 3) reads raw AND enable; writes to it change nothing.
- R7: wake_o is 1 exactly when some bit of either group is both latched and enabled, and it stays 1 across idle cycles until cleared or disabled.
- R8: When a clear write to a raw bit and a new qualifying edge of that bit fall in the same cycle, the bit stays set.
- R9: Address bit 2 selects the group (0 internal, 1 pin) and bits 1:0 select the register (0 enable, 1 polarity, 2 raw, 3 masked); a write to one group leaves the other group's registers unchanged.
- R10: A source transition applied before a clock edge is visible in raw status after the third rising edge from then, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_src_i | input | W | Internal wake sources, asynchronous |
| pin_src_i | input | W | External pin wake sources, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address: group in bit 2, register in bits 1:0 |
| wr_data_i | input | W | Write data |
| rd_addr_i | input | 3 | Read address, same encoding |
| rd_data_o | output | W | Read data, combinational from rd_addr_i |
| wake_o | output | 1 | Combined wake request |

## Verification
The checks take for granted that latched bits fall and wake_o drops only through a register write, and that each source holds its level for at least two clock cycles so a pulse cannot slip past the synchronizer. The stimulus changes source levels only between clock edges, holds every level for at least four cycles, and keeps the write strobe low during every idle window in which wake_o is expected to hold. The one deliberate overlap of a clear write and an edge is aligned to the third edge after the source change.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [1:0] SEL_EN  = 2'd0;
  localparam logic [1:0] SEL_POL = 2'd1;
  localparam logic [1:0] SEL_RAW = 2'd2;
  localparam logic [1:0] SEL_MSK = 2'd3;
  localparam int unsigned GRP_INT = 0;
  localparam int unsigned GRP_PIN = 1;
  localparam int unsigned N_GRP   = 2;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/wake_group.sv
module wake_group
  import wake_pkg::*;
#(
  parameter int unsigned W       = 32,
  parameter logic [W-1:0] POL_RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         arm_i,
  input  logic [W-1:0] src_i,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] msk_o
);
  logic [W-1:0] prev_q, en_q, pol_q, raw_q;
  logic [W-1:0] evt, clr;

  // edge on selected polarity, suppressed until the sampled history is valid
  assign evt = arm_i ? ((src_i & ~prev_q & pol_q) | (~src_i & prev_q & ~pol_q)) : '0;
  assign clr = (wr_en_i && wr_sel_i == SEL_RAW) ? wr_data_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      en_q   <= '0;
      pol_q  <= POL_RST;
      raw_q  <= '0;
    end else begin
      prev_q <= src_i;
      raw_q  <= (raw_q & ~clr) | evt;  // new event wins over clear
      if (wr_en_i && wr_sel_i == SEL_EN)  en_q  <= wr_data_i;
      if (wr_en_i && wr_sel_i == SEL_POL) pol_q <= wr_data_i;
    end
  end

  assign en_o  = en_q;
  assign pol_o = pol_q;
  assign raw_o = raw_q;
  assign msk_o = raw_q & en_q;
endmodule

// File: rtl/wake_latch_unit.sv
module wake_latch_unit
  import wake_pkg::*;
#(
  parameter int unsigned  W           = 32,
  parameter int unsigned  SYNC_STAGES = 2,
  parameter logic [W-1:0] INT_POL_RST = 32'h0000_0700,
  parameter logic [W-1:0] PIN_POL_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      int_src_i,
  input  logic [W-1:0]      pin_src_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [W-1:0]      rd_data_o,
  output logic              wake_o
);
  localparam int unsigned ARM_CYC = SYNC_STAGES + 1;
  localparam int unsigned CNT_W   = $clog2(ARM_CYC + 1);

  logic [CNT_W-1:0] arm_cnt_q;
  logic             arm;
  logic [W-1:0]     src_w [N_GRP];
  logic [W-1:0]     sync_w [N_GRP];
  logic [W-1:0]     en_w [N_GRP];
  logic [W-1:0]     pol_w [N_GRP];
  logic [W-1:0]     raw_w [N_GRP];
  logic [W-1:0]     msk_w [N_GRP];

  assign src_w[GRP_INT] = int_src_i;
  assign src_w[GRP_PIN] = pin_src_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    arm_cnt_q <= '0;
    else if (!arm)  arm_cnt_q <= arm_cnt_q + CNT_W'(1);
  end
  assign arm = (arm_cnt_q == CNT_W'(ARM_CYC));

  for (genvar g = 0; g < int'(N_GRP); g++) begin : g_grp
    wake_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (src_w[g]),
      .q_o   (sync_w[g])
    );
    wake_group #(.W(W), .POL_RST(g == GRP_INT ? INT_POL_RST : PIN_POL_RST)) u_grp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .arm_i    (arm),
      .src_i    (sync_w[g]),
      .wr_en_i  (wr_en_i && (wr_addr_i[2] == 1'(g))),
      .wr_sel_i (wr_addr_i[1:0]),
      .wr_data_i(wr_data_i),
      .en_o     (en_w[g]),
      .pol_o    (pol_w[g]),
      .raw_o    (raw_w[g]),
      .msk_o    (msk_w[g])
    );
  end

  always_comb begin
    unique case (rd_addr_i[1:0])
      SEL_EN:  rd_data_o = en_w[rd_addr_i[2]];
      SEL_POL: rd_data_o = pol_w[rd_addr_i[2]];
      SEL_RAW: rd_data_o = raw_w[rd_addr_i[2]];
      default: rd_data_o = msk_w[rd_addr_i[2]];
    endcase
  end

  assign wake_o = |(msk_w[GRP_INT] | msk_w[GRP_PIN]);
endmodule

// File: rtl/wake_latch_chk.sv
module wake_latch_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_en_i,
  input logic [W-1:0] raw_int_i,
  input logic [W-1:0] raw_pin_i,
  input logic [W-1:0] en_int_i,
  input logic [W-1:0] en_pin_i,
  input logic         wake_o
);
  // R7: wake only with some enable set
  a_r7_wake_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> ((en_int_i | en_pin_i) != '0));

  // R7: wake holds across a cycle with no write
  a_r7_wake_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_o && !wr_en_i) |=> wake_o);

  // R5: latched internal bits drop only through a write
  a_r5_int_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((raw_int_i & $past(raw_int_i)) == $past(raw_int_i)));

  // R5: latched pin bits drop only through a write
  a_r5_pin_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ((raw_pin_i & $past(raw_pin_i)) == $past(raw_pin_i)));

  // R4: enables change only through a write
  a_r4_en_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(en_int_i) && $stable(en_pin_i)));
endmodule

bind wake_latch_unit wake_latch_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .raw_int_i(raw_w[0]),
  .raw_pin_i(raw_w[1]),
  .en_int_i (en_w[0]),
  .en_pin_i (en_w[1]),
  .wake_o   (wake_o)
);

// File: tb/sim_wake_latch_unit.sv
module sim_wake_latch_unit;
  localparam int W = 32;
  localparam logic [2:0] A_INT_EN = 3'd0, A_INT_POL = 3'd1, A_INT_RAW = 3'd2, A_INT_MSK = 3'd3;
  localparam logic [2:0] A_PIN_EN = 3'd4, A_PIN_POL = 3'd5, A_PIN_RAW = 3'd6, A_PIN_MSK = 3'd7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] int_src = 32'h0000_0700;
  logic [W-1:0] pin_src = '1;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [2:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic         wake;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  wake_latch_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .int_src_i(int_src), .pin_src_i(pin_src),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .wake_o(wake)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rdchk(input string tag, input logic [2:0] a, input logic [W-1:0] exp);
    rd_addr = a; #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (6) @(negedge clk);
    rdchk("R1 int en", A_INT_EN, '0);
    rdchk("R1 pin en", A_PIN_EN, '0);
    rdchk("R1 int pol", A_INT_POL, 32'h0000_0700);
    rdchk("R1 pin pol", A_PIN_POL, '0);
    rdchk("R1 int raw", A_INT_RAW, '0);
    rdchk("R1 pin raw", A_PIN_RAW, '0);
    chk("R1 wake", W'(wake), '0);
    int_src = '0; settle();
    rdchk("R2 falling ignored on rising pol", A_INT_RAW, '0);
  endtask

  task automatic t_latency();
    wr(A_INT_POL, 32'h0000_0708);
    int_src[3] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rdchk("R10 not after two edges", A_INT_RAW, '0);
    @(posedge clk); @(negedge clk);
    rdchk("R10 set after third edge", A_INT_RAW, 32'h8);
    chk("R4 disabled bit no wake", W'(wake), '0);
    wr(A_INT_RAW, 32'h8);
    rdchk("R5 cleared", A_INT_RAW, '0);
  endtask

  task automatic t_rising();
    int_src[3] = 1'b0; settle();
    rdchk("R2 fall ignored", A_INT_RAW, '0);
    int_src[3] = 1'b1; settle();
    rdchk("R2 rise latched", A_INT_RAW, 32'h8);
    wr(A_INT_RAW, 32'h8);
  endtask

  task automatic t_falling();
    pin_src[5] = 1'b0; settle();
    rdchk("R3 fall latched", A_PIN_RAW, 32'h20);
    wr(A_PIN_RAW, 32'h20);
    pin_src[5] = 1'b1; settle();
    rdchk("R3 rise ignored", A_PIN_RAW, '0);
  endtask

  task automatic t_w1c();
    pin_src[5] = 1'b0; pin_src[6] = 1'b0; settle();
    rdchk("R4 both latched while disabled", A_PIN_RAW, 32'h60);
    chk("R4 wake low while disabled", W'(wake), '0);
    wr(A_PIN_RAW, 32'h20);
    rdchk("R5 only written bit cleared", A_PIN_RAW, 32'h40);
    wr(A_PIN_RAW, 32'h0);
    rdchk("R5 zero write keeps bits", A_PIN_RAW, 32'h40);
  endtask

  task automatic t_mask_wake();
    wr(A_PIN_EN, 32'h40);
    rdchk("R6 masked read", A_PIN_MSK, 32'h40);
    chk("R7 wake from pin", W'(wake), 1);
    wr(A_PIN_MSK, 32'h0);
    rdchk("R6 masked write ignored", A_PIN_RAW, 32'h40);
    repeat (5) @(negedge clk);
    chk("R7 wake holds", W'(wake), 1);
    wr(A_PIN_EN, 32'h0);
    chk("R7 wake drops on disable", W'(wake), 0);
    rdchk("R6 masked zero when disabled", A_PIN_MSK, '0);
    int_src[3] = 1'b0; settle();
    int_src[3] = 1'b1; settle();
    wr(A_INT_EN, 32'h8);
    chk("R7 wake from internal group", W'(wake), 1);
    wr(A_INT_RAW, 32'h8);
    chk("R7 wake drops on clear", W'(wake), 0);
    wr(A_INT_EN, 32'h0);
    wr(A_PIN_RAW, 32'h40);
  endtask

  task automatic t_collide();
    pin_src[5] = 1'b1; settle();
    pin_src[5] = 1'b0; settle();
    rdchk("R8 pre latched", A_PIN_RAW, 32'h20);
    pin_src[5] = 1'b1; settle();
    @(negedge clk); pin_src[5] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = A_PIN_RAW; wr_data = 32'h20;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
    rdchk("R8 event wins over clear", A_PIN_RAW, 32'h20);
    wr(A_PIN_RAW, 32'h20);
    rdchk("R5 clear after collision", A_PIN_RAW, '0);
  endtask

  task automatic t_groups();
    wr(A_INT_EN, 32'hFFFF_0000);
    rdchk("R9 pin en untouched", A_PIN_EN, '0);
    rdchk("R9 int en written", A_INT_EN, 32'hFFFF_0000);
    wr(A_PIN_POL, 32'h1);
    rdchk("R9 int pol untouched", A_INT_POL, 32'h0000_0708);
    rdchk("R9 pin pol written", A_PIN_POL, 32'h1);
    chk("R9 no wake without latched bits", W'(wake), 0);
    wr(A_INT_EN, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latency();
    t_rising();
    t_falling();
    t_w1c();
    t_mask_wake();
    t_collide();
    t_groups();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule